// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block holds a bank of receive mailboxes for a CAN controller. Each time the protocol engine hands over an accepted frame, the allocator places it in the lowest-numbered mailbox that can take it. The host then reads the mailbox's identifier, status word and two data words through a select port. Storage is always to the lowest free slot. There is no circular write pointer, so the host recovers arrival order by draining the mailboxes in index order.

A plain mailbox that holds a frame stays closed until the host releases it. The host does this by writing a bit mask in which every 1 re-opens the matching mailbox. The highest mailbox can be built in overwrite mode. In that mode it always accepts a frame. If it still holds unread data when a new frame arrives, the frame replaces that data in place and a message-lost flag is set.

Without an overwrite mailbox, a frame that finds no free mailbox is discarded and a saturating drop counter is incremented. Each store raises a one-cycle interrupt pulse for the mailbox that was written. The ready bits are also mirrored into a global status word.

Top module: `rxmb_alloc`

## Requirements
- R1: After reset every mailbox is empty: ready bits, global status, interrupt pulses and drop counter are all zero.
- R2: A frame strobed on `frm_valid_i` is stored in the lowest-indexed eligible mailbox. That mailbox's ready bit and contents are visible from the clock edge that sampled the strobe.
- R3: A plain mailbox that holds a frame is not written again until it is released. A later frame goes to the next eligible mailbox instead.
- R4: With `LAST_OVERWRITE`=1, the highest mailbox is always eligible but is used only when every lower mailbox is full. A store into it while its ready bit is set replaces the contents and sets the lost flag.
- R5: The status word carries the DLC in bits 19:16, the remote-request flag in bit 20, ready in bit 23 and message-lost in bit 24, with all other bits zero. `rd_id_o` returns the 29-bit identifier, `rd_ext_o` the extended-format flag, `rd_data_lo_o` data bits 31:0 and `rd_data_hi_o` data bits 63:32.
- R6: A release write clears the ready and lost flags of every mailbox whose mask bit is 1. Mailboxes whose mask bit is 0 keep their state. Stored identifier and data are not erased.
- R7: When a release write and a frame arrive in the same cycle, the release is applied first, so a mailbox freed by it can receive that frame.
- R8: Bits NUM_MB-1:0 of `gstat_o` equal the mailbox ready bits, and the bits above them are zero.
- R9: After each store, `irq_o` has exactly the written mailbox's bit set for one cycle. It is zero otherwise.
- R10: With no eligible mailbox, a frame is dropped: no mailbox changes, and `drop_cnt_o` increments, saturating at its maximum.
- R11: `rd_mode_o` reports mode code 1 for a plain receive mailbox and code 2 for the overwrite mailbox.
- R12: Changing `rd_sel_i` to read any mailbox, including its data words, leaves all ready flags and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid_i | input | 1 | Accepted-frame strobe, one cycle per frame |
| frm_ext_i | input | 1 | Frame uses the extended identifier format |
| frm_rtr_i | input | 1 | Frame is a remote request |
| frm_id_i | input | 29 | Frame identifier |
| frm_dlc_i | input | 4 | Data length code |
| frm_data_i | input | 64 | Eight data bytes, byte 0 in bits 7:0 |
| rel_we_i | input | 1 | Release write strobe |
| rel_mask_i | input | NUM_MB | Mailboxes to re-open (1 = release) |
| rd_sel_i | input | IDX_W | Mailbox selected for reading |
| rd_id_o | output | 29 | Identifier of the selected mailbox |
| rd_ext_o | output | 1 | Extended flag of the selected mailbox |
| rd_mode_o | output | 3 | Mode code of the selected mailbox |
| rd_status_o | output | 32 | Status word of the selected mailbox |
| rd_data_lo_o | output | 32 | Data bits 31:0 of the selected mailbox |
| rd_data_hi_o | output | 32 | Data bits 63:32 of the selected mailbox |
| ready_o | output | NUM_MB | Per-mailbox ready bits |
| gstat_o | output | GSTAT_W | Global status word with ready bits at the bottom |
| irq_o | output | NUM_MB | One-cycle store pulse per mailbox |
| drop_cnt_o | output | DROP_W | Saturating count of dropped frames |

## Verification
The bench builds two copies of the block. The first uses the defaults: twelve mailboxes with the top one in overwrite mode. This reaches lowest-slot refill after a partial release, overwrite with loss, and release colliding with a store. The second uses four mailboxes, no overwrite mailbox and a 2-bit drop counter. With that build a full bank and counter saturation take only a few frames, and the dropped-frame path is reachable at all.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    localparam int ST_DLC_LSB = 16;
    localparam int ST_RTR_BIT = 20;
    localparam int ST_RDY_BIT = 23;
    localparam int ST_LOST_BIT = 24;

    typedef enum logic [2:0] {
        MB_MODE_OFF    = 3'd0,
        MB_MODE_RX     = 3'd1,
        MB_MODE_RX_OVR = 3'd2
    } mb_mode_e;

    typedef struct packed {
        logic              ext;
        logic              rtr;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        frame_t frm;
        logic   ready;
        logic   lost;
    } slot_t;

endpackage

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
    parameter int N     = 12,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     elig_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rxmb_slot.sv
module rxmb_slot
    import rxmb_pkg::*;
#(
    parameter bit OVERWRITE = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rel_i,
    input  logic   wr_i,
    input  frame_t frm_i,
    output slot_t  slot_o
);

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (rel_i) begin
            slot_d.ready = 1'b0;
            slot_d.lost  = 1'b0;
        end
        if (wr_i) begin
            if (OVERWRITE) begin
                slot_d.lost = slot_d.lost | slot_d.ready;
            end
            slot_d.frm   = frm_i;
            slot_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_o = slot_q;

    // A plain mailbox must only be written when empty or freed this cycle.
    assert_plain_no_rewrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rel_i && !OVERWRITE) |-> !slot_q.ready);

    assert_store_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> slot_q.ready);

    assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !wr_i) |=> (!slot_q.ready && !slot_q.lost));

    assert_overwrite_flags_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (OVERWRITE && wr_i && !rel_i && slot_q.ready) |=> slot_q.lost);

    assert_contents_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(slot_q.frm));

endmodule

// File: rtl/rxmb_alloc.sv
module rxmb_alloc
    import rxmb_pkg::*;
#(
    parameter  int NUM_MB         = 12,
    parameter  bit LAST_OVERWRITE = 1'b1,
    parameter  int DROP_W         = 8,
    parameter  int GSTAT_W        = 32,
    localparam int IDX_W          = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid_i,
    input  logic                frm_ext_i,
    input  logic                frm_rtr_i,
    input  logic [28:0]         frm_id_i,
    input  logic [3:0]          frm_dlc_i,
    input  logic [63:0]         frm_data_i,
    input  logic                rel_we_i,
    input  logic [NUM_MB-1:0]   rel_mask_i,
    input  logic [IDX_W-1:0]    rd_sel_i,
    output logic [28:0]         rd_id_o,
    output logic                rd_ext_o,
    output logic [2:0]          rd_mode_o,
    output logic [31:0]         rd_status_o,
    output logic [31:0]         rd_data_lo_o,
    output logic [31:0]         rd_data_hi_o,
    output logic [NUM_MB-1:0]   ready_o,
    output logic [GSTAT_W-1:0]  gstat_o,
    output logic [NUM_MB-1:0]   irq_o,
    output logic [DROP_W-1:0]   drop_cnt_o
);

    localparam logic [IDX_W:0]   NUM_MB_L = (IDX_W + 1)'(NUM_MB);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MB - 1);

    typedef struct packed {
        logic [NUM_MB-1:0] irq;
        logic [DROP_W-1:0] drop;
    } top_st_t;

    top_st_t st_d, st_q;

    slot_t             slot_q [NUM_MB];
    frame_t            frm_in;
    logic [NUM_MB-1:0] rel_vec;
    logic [NUM_MB-1:0] elig;
    logic [NUM_MB-1:0] wr_vec;
    logic              hit;
    logic [IDX_W-1:0]  pick_idx;
    slot_t             rd_slot;

    assign frm_in  = '{ext: frm_ext_i, rtr: frm_rtr_i, id: frm_id_i,
                       dlc: frm_dlc_i, data: frm_data_i};
    assign rel_vec = rel_we_i ? rel_mask_i : '0;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        localparam bit IS_OVR = LAST_OVERWRITE && (g == NUM_MB - 1);
        if (IS_OVR) begin : g_ovr
            assign elig[g] = 1'b1;
        end else begin : g_plain
            // release takes effect before the store decision
            assign elig[g] = !slot_q[g].ready || rel_vec[g];
        end
        assign wr_vec[g]  = frm_valid_i && hit && (pick_idx == IDX_W'(g));
        assign ready_o[g] = slot_q[g].ready;

        rxmb_slot #(.OVERWRITE(IS_OVR)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .rel_i  (rel_vec[g]),
            .wr_i   (wr_vec[g]),
            .frm_i  (frm_in),
            .slot_o (slot_q[g])
        );
    end

    rxmb_pick #(.N(NUM_MB), .IDX_W(IDX_W)) pick_i (
        .elig_i (elig),
        .hit_o  (hit),
        .idx_o  (pick_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = wr_vec;
        if (frm_valid_i && !hit && !(&st_q.drop)) begin
            st_d.drop = st_q.drop + DROP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_slot   = '0;
        rd_mode_o = MB_MODE_OFF;
        if ({1'b0, rd_sel_i} < NUM_MB_L) begin
            rd_slot   = slot_q[rd_sel_i];
            rd_mode_o = (LAST_OVERWRITE && rd_sel_i == LAST_IDX) ? MB_MODE_RX_OVR : MB_MODE_RX;
        end
        rd_status_o = '0;
        rd_status_o[ST_DLC_LSB +: DLC_W] = rd_slot.frm.dlc;
        rd_status_o[ST_RTR_BIT]          = rd_slot.frm.rtr;
        rd_status_o[ST_RDY_BIT]          = rd_slot.ready;
        rd_status_o[ST_LOST_BIT]         = rd_slot.lost;
    end

    assign rd_id_o      = rd_slot.frm.id;
    assign rd_ext_o     = rd_slot.frm.ext;
    assign rd_data_lo_o = rd_slot.frm.data[31:0];
    assign rd_data_hi_o = rd_slot.frm.data[63:32];
    assign gstat_o      = GSTAT_W'(ready_o);
    assign irq_o        = st_q.irq;
    assign drop_cnt_o   = st_q.drop;

    // ---------------- assertions ----------------
    logic [NUM_MB-1:0] below_pick;
    assign below_pick = (NUM_MB'(1) << pick_idx) - NUM_MB'(1);

    assert_pick_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && hit) |-> (elig[pick_idx] && ((elig & below_pick) == '0)));

    assert_release_before_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && rel_we_i && rel_mask_i[0]) |=> (ready_o[0] && irq_o[0]));

    assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    assert_irq_implies_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~ready_o) == '0);

    assert_drop_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && elig == '0 && !(&drop_cnt_o)) |=> drop_cnt_o == $past(drop_cnt_o) + DROP_W'(1));

    assert_drop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_valid_i || elig != '0) |=> $stable(drop_cnt_o));

    assert_drop_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && elig == '0 && !rel_we_i) |=> $stable(ready_o));

endmodule

// File: tb/rxmb_alloc_tb_top.sv
`timescale 1ns/1ps
module rxmb_alloc_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // shared frame fields
    logic        frm_valid = 1'b0, s_valid = 1'b0;
    logic        frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;

    // main instance
    logic        rel_we = 1'b0;
    logic [11:0] rel_mask = '0;
    logic [3:0]  rd_sel = '0;
    logic [28:0] rd_id;
    logic        rd_ext;
    logic [2:0]  rd_mode;
    logic [31:0] rd_status, rd_lo, rd_hi;
    logic [11:0] ready, irq;
    logic [31:0] gstat;
    logic [7:0]  drop;

    rxmb_alloc dut_i (
        .clk(clk), .rst_n(rst_n),
        .frm_valid_i(frm_valid), .frm_ext_i(frm_ext), .frm_rtr_i(frm_rtr),
        .frm_id_i(frm_id), .frm_dlc_i(frm_dlc), .frm_data_i(frm_data),
        .rel_we_i(rel_we), .rel_mask_i(rel_mask), .rd_sel_i(rd_sel),
        .rd_id_o(rd_id), .rd_ext_o(rd_ext), .rd_mode_o(rd_mode),
        .rd_status_o(rd_status), .rd_data_lo_o(rd_lo), .rd_data_hi_o(rd_hi),
        .ready_o(ready), .gstat_o(gstat), .irq_o(irq), .drop_cnt_o(drop)
    );

    // small instance: four mailboxes, no overwrite slot, 2-bit drop counter
    logic [1:0]  s_rd_sel = '0;
    logic [28:0] s_rd_id;
    logic        s_rd_ext;
    logic [2:0]  s_rd_mode;
    logic [31:0] s_rd_status, s_rd_lo, s_rd_hi;
    logic [3:0]  s_ready, s_irq;
    logic [7:0]  s_gstat;
    logic [1:0]  s_drop;

    rxmb_alloc #(.NUM_MB(4), .LAST_OVERWRITE(1'b0), .DROP_W(2), .GSTAT_W(8)) dut_small_i (
        .clk(clk), .rst_n(rst_n),
        .frm_valid_i(s_valid), .frm_ext_i(frm_ext), .frm_rtr_i(frm_rtr),
        .frm_id_i(frm_id), .frm_dlc_i(frm_dlc), .frm_data_i(frm_data),
        .rel_we_i(1'b0), .rel_mask_i(4'h0), .rd_sel_i(s_rd_sel),
        .rd_id_o(s_rd_id), .rd_ext_o(s_rd_ext), .rd_mode_o(s_rd_mode),
        .rd_status_o(s_rd_status), .rd_data_lo_o(s_rd_lo), .rd_data_hi_o(s_rd_hi),
        .ready_o(s_ready), .gstat_o(s_gstat), .irq_o(s_irq), .drop_cnt_o(s_drop)
    );

    int n_chk = 0;
    int n_miss = 0;
    bit done = 1'b0;

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] data_of(logic [28:0] id);
        return {32'hA5A50000 ^ 32'(id), 32'h5A5A0000 ^ 32'(id)};
    endfunction

    // R5 status layout: dlc 19:16, rtr 20, ready 23, lost 24
    function automatic logic [31:0] status_of(logic [28:0] id, logic rdy, logic lost);
        return (32'(lost) << 24) | (32'(rdy) << 23) | (32'(id[0]) << 20) | (32'(id[3:0]) << 16);
    endfunction

    function automatic logic [127:0] view_of(logic [28:0] id, logic rdy, logic lost);
        return {2'b0, id[1], id, status_of(id, rdy, lost), data_of(id)};
    endfunction

    task automatic put_frame(logic [28:0] id);
        frm_id   = id;
        frm_ext  = id[1];
        frm_rtr  = id[0];
        frm_dlc  = id[3:0];
        frm_data = data_of(id);
    endtask

    typedef struct packed {
        logic        fv;
        logic [28:0] id;
        logic        rw;
        logic [11:0] rm;
        logic [11:0] er;
        logic [11:0] ei;
        logic [3:0]  cm;
        logic [28:0] cid;
        logic        cl;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 29'h100, 1'b0, 12'h000, 12'h001, 12'h001, 4'd0,  29'h100, 1'b0},
        '{1'b1, 29'h101, 1'b0, 12'h000, 12'h003, 12'h002, 4'd1,  29'h101, 1'b0},
        '{1'b0, 29'h000, 1'b1, 12'h001, 12'h002, 12'h000, 4'd1,  29'h101, 1'b0},
        '{1'b1, 29'h102, 1'b0, 12'h000, 12'h003, 12'h001, 4'd0,  29'h102, 1'b0},
        '{1'b1, 29'h103, 1'b0, 12'h000, 12'h007, 12'h004, 4'd2,  29'h103, 1'b0},
        '{1'b1, 29'h104, 1'b0, 12'h000, 12'h00F, 12'h008, 4'd3,  29'h104, 1'b0},
        '{1'b1, 29'h105, 1'b0, 12'h000, 12'h01F, 12'h010, 4'd4,  29'h105, 1'b0},
        '{1'b1, 29'h106, 1'b0, 12'h000, 12'h03F, 12'h020, 4'd5,  29'h106, 1'b0},
        '{1'b1, 29'h107, 1'b0, 12'h000, 12'h07F, 12'h040, 4'd6,  29'h107, 1'b0},
        '{1'b1, 29'h108, 1'b0, 12'h000, 12'h0FF, 12'h080, 4'd7,  29'h108, 1'b0},
        '{1'b1, 29'h109, 1'b0, 12'h000, 12'h1FF, 12'h100, 4'd8,  29'h109, 1'b0},
        '{1'b1, 29'h10A, 1'b0, 12'h000, 12'h3FF, 12'h200, 4'd9,  29'h10A, 1'b0},
        '{1'b1, 29'h10B, 1'b0, 12'h000, 12'h7FF, 12'h400, 4'd10, 29'h10B, 1'b0},
        '{1'b1, 29'h10C, 1'b0, 12'h000, 12'hFFF, 12'h800, 4'd11, 29'h10C, 1'b0},
        '{1'b1, 29'h200, 1'b0, 12'h000, 12'hFFF, 12'h800, 4'd11, 29'h200, 1'b1},
        '{1'b1, 29'h201, 1'b1, 12'h004, 12'hFFF, 12'h004, 4'd2,  29'h201, 1'b0},
        '{1'b0, 29'h000, 1'b1, 12'h800, 12'h7FF, 12'h000, 4'd11, 29'h200, 1'b0},
        '{1'b1, 29'h202, 1'b0, 12'h000, 12'hFFF, 12'h800, 4'd11, 29'h202, 1'b0},
        '{1'b1, 29'h203, 1'b1, 12'h800, 12'hFFF, 12'h800, 4'd11, 29'h203, 1'b0},
        '{1'b0, 29'h000, 1'b1, 12'hFFF, 12'h000, 12'h000, 4'd0,  29'h102, 1'b0}
    };

    function automatic string vtag(int v);
        case (v)
            2, 16, 19: return "R6";
            3:         return "R3";
            14, 17:    return "R4";
            15, 18:    return "R7";
            default:   return "R2";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_miss);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "ready", 128'(ready), 128'h0);
        chk("R1", "gstat", 128'(gstat), 128'h0);
        chk("R1", "irq", 128'(irq), 128'h0);
        chk("R1", "drop", 128'(drop), 128'h0);
        chk("R1", "small ready", 128'(s_ready), 128'h0);

        // R11: mode codes
        rd_sel = 4'd0;  #1 chk("R11", "mode mb0", 128'(rd_mode), 128'd1);
        rd_sel = 4'd5;  #1 chk("R11", "mode mb5", 128'(rd_mode), 128'd1);
        rd_sel = 4'd11; #1 chk("R11", "mode mb11", 128'(rd_mode), 128'd2);

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            frm_valid = VEC[v].fv;
            put_frame(VEC[v].id);
            rel_we   = VEC[v].rw;
            rel_mask = VEC[v].rm;
            @(negedge clk);
            frm_valid = 1'b0;
            rel_we    = 1'b0;
            rel_mask  = '0;
            rd_sel    = VEC[v].cm;
            #1;
            chk(vtag(v), $sformatf("vec %0d ready", v), 128'(ready), 128'(VEC[v].er));
            chk("R8", $sformatf("vec %0d gstat", v), 128'(gstat), 128'(VEC[v].er));
            chk("R9", $sformatf("vec %0d irq", v), 128'(irq), 128'(VEC[v].ei));
            chk("R5", $sformatf("vec %0d contents", v),
                {2'b0, rd_ext, rd_id, rd_status, rd_hi, rd_lo},
                view_of(VEC[v].cid, VEC[v].er[VEC[v].cm], VEC[v].cl));
        end

        // R9: pulse lasts one cycle; R2 after full release lands in mb0
        @(negedge clk);
        frm_valid = 1'b1;
        put_frame(29'h1ABCDEF3);
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R9", "pulse on", 128'(irq), 128'h001);
        @(negedge clk);
        chk("R9", "pulse off", 128'(irq), 128'h000);

        // R12: sweep reads, nothing changes
        for (int k = 0; k < 12; k++) begin
            rd_sel = 4'(k);
            @(negedge clk);
        end
        rd_sel = 4'd0;
        #1;
        chk("R12", "ready after reads", 128'(ready), 128'h001);
        chk("R12", "mb0 after reads", {2'b0, rd_ext, rd_id, rd_status, rd_hi, rd_lo},
            view_of(29'h1ABCDEF3, 1'b1, 1'b0));
        chk("R10", "no drop with overwrite slot", 128'(drop), 128'h0);

        // R10 on the small build
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            put_frame(29'h40 + 29'(k));
        end
        @(negedge clk);
        s_valid = 1'b0;
        chk("R10", "small full", 128'(s_ready), 128'hF);
        chk("R10", "small no drop yet", 128'(s_drop), 128'h0);
        @(negedge clk);
        s_valid = 1'b1;
        put_frame(29'h3FF);
        @(negedge clk);
        s_valid = 1'b0;
        s_rd_sel = 2'd3;
        #1;
        chk("R10", "drop one", 128'(s_drop), 128'h1);
        chk("R10", "irq after drop", 128'(s_irq), 128'h0);
        chk("R10", "mb3 untouched", {2'b0, s_rd_ext, s_rd_id, s_rd_status, s_rd_hi, s_rd_lo},
            view_of(29'h43, 1'b1, 1'b0));
        chk("R11", "small mode mb3", 128'(s_rd_mode), 128'd1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            put_frame(29'h500 + 29'(k));
        end
        @(negedge clk);
        s_valid = 1'b0;
        chk("R10", "drop saturates", 128'(s_drop), 128'h3);
        chk("R10", "small still full", 128'(s_ready), 128'hF);

        finish_run();
    end

endmodule